// File: doc/BRIEF.md
# Multicycle Control Sequencer

This block is the control unit of a multicycle processor core for a small integer instruction subset. A four-bit state register steps each instruction through fetch, decode and one or more execute states. Every cycle it tells the surrounding datapath four things: which address feeds the memory, which operands the ALU uses, which result is routed back, and which architectural or staging registers are written. The datapath itself, including the memory, register file, ALU and staging registers, sits outside the block. The block only drives control lines.

The sequencer handles loads, stores, register-register add/sub/and/or/slt, add-immediate, equal-branch and the standard jump-and-link. It also handles one custom jump (opcode 7'b1101110) whose return address is the instruction address plus 8. After decode, the staging ALU register already holds the jump target. A dedicated state therefore loads the PC from that register and, in the same cycle, adds 4 to the already-incremented PC. The existing register-writeback state then stores the result into rd.

Apart from the PC write enable, the ALU function and the immediate format, every output depends on the current state alone.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in Fetch (code 0). Fetch drives pc_we=1, addr_sel=0, mem_we=0, ir_we=1, rf_we=0, res_sel=10, alu_a_sel=00, alu_b_sel=10, alu_ctl=000.
- R2: Fetch is always followed by Decode (code 1). Decode drives pc_we=0, all write enables 0, res_sel=00, alu_a_sel=01, alu_b_sel=01, alu_ctl=000. Select encodings are as follows. For res_sel: 00 is the ALU result register, 01 is the memory data register, 10 is the live ALU output. For alu_a_sel: 00 is the PC, 01 is the old PC, 10 is register A. For alu_b_sel: 00 is register B, 01 is the immediate, 10 is the constant 4.
- R3: A load (opcode 0000011) runs Decode → MemAddr (2) → MemRead (3) → MemWB (4) → Fetch. MemAddr drives alu_a_sel=10 and alu_b_sel=01. MemRead drives addr_sel=1. MemWB drives rf_we=1 and res_sel=01.
- R4: A store (opcode 0100011) runs Decode → MemAddr → MemWrite (5) → Fetch. MemWrite drives addr_sel=1 and mem_we=1, with rf_we=0.
- R5: A register-register operation (opcode 0110011) runs Decode → ExecuteR (6) → ALUWB (7) → Fetch. ExecuteR drives alu_a_sel=10 and alu_b_sel=00. ALUWB drives rf_we=1 and res_sel=00. The ALU function in ExecuteR is chosen from funct3 as follows: 000 gives add (000), or sub (001) when funct7 bit 5 is set; 010 gives slt (101); 110 gives or (011); 111 gives and (010); any other funct3 gives 000.
- R6: An immediate ALU operation (opcode 0010011) runs Decode → ExecuteI (8) → ALUWB → Fetch. ExecuteI drives alu_a_sel=10 and alu_b_sel=01 and uses the funct3 decode of R5. With funct3=000 it adds even when funct7 bit 5 is set.
- R7: The jump-and-link (opcode 1101111) runs Decode → JAL (9) → ALUWB → Fetch. JAL drives pc_we=1, alu_a_sel=01, alu_b_sel=10, res_sel=00 and alu_ctl=000.
- R8: The equal-branch (opcode 1100011) runs Decode → BEQ (10) → Fetch. BEQ drives alu_a_sel=10, alu_b_sel=00 and alu_ctl=001 (subtract), with no register or memory write.
- R9: The custom jump (opcode 1101110) runs Decode → JumpPlus8 (11) → ALUWB → Fetch. JumpPlus8 moves to ALUWB whatever the opcode is at that time. JumpPlus8 drives pc_we=1, res_sel=00, alu_a_sel=00, alu_b_sel=10, alu_ctl=000, and rf_we=mem_we=ir_we=0.
- R10: imm_sel follows the opcode in every state: 000 for load and immediate ALU, 001 for store, 010 for the branch, 011 for both jumps, and 000 for anything else.
- R11: Any other opcode in Decode returns to Fetch on the next edge, so the instruction spends exactly two cycles in the sequencer and produces no register or memory write.
- R12: pc_we is high when the state requests a PC update, or when it is BEQ and alu_zero is high. alu_zero has no effect in any other state.
- R13: alu_ctl is 000 in every state other than ExecuteR, ExecuteI and BEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 7 | Opcode field of the held instruction |
| funct3 | input | 3 | funct3 field of the held instruction |
| funct7_b5 | input | 1 | Bit 5 of the funct7 field |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_we | output | 1 | PC write enable |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_we | output | 1 | Memory write enable |
| ir_we | output | 1 | Instruction and old-PC register write enable |
| rf_we | output | 1 | Register file write enable |
| res_sel | output | 2 | Result multiplexer select |
| alu_a_sel | output | 2 | ALU operand A select |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_ctl | output | 3 | ALU function code |
| imm_sel | output | 3 | Immediate format select |

## Verification
The bench runs every one of the 128 opcode values through a full instruction from reset. Each cycle's control word is compared with a state model derived from the requirements. This separates the seven recognised paths from the unrecognised ones and catches a misdecoded opcode, whether it leads to a wrong state or to a wrong exit count. Register and immediate ALU forms are each swept over all funct3 and funct7-bit-5 combinations, which tells the subtract, slt, or and and codes apart and shows that add-immediate ignores funct7. alu_zero toggles every cycle, so its effect is seen only in BEQ and never elsewhere. The opcode is changed while the sequencer is in JumpPlus8 to show that the exit to writeback does not depend on it.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int ST_W   = 4;
    localparam int SEL_W  = 2;
    localparam int ALUC_W = 3;
    localparam int IMM_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDREAD = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STORE  = 4'd5,
        ST_EXE_R  = 4'd6,
        ST_WB     = 4'd7,
        ST_EXE_I  = 4'd8,
        ST_JUMP   = 4'd9,
        ST_BRANCH = 4'd10,
        ST_JUMP8  = 4'd11
    } state_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_ALU_R = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_ALU_I = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 7'b1100011;

    // Result select codes
    localparam logic [SEL_W-1:0] RES_ALUREG = 2'b00;
    localparam logic [SEL_W-1:0] RES_MEMDAT = 2'b01;
    localparam logic [SEL_W-1:0] RES_ALULIVE = 2'b10;
    // Operand A codes
    localparam logic [SEL_W-1:0] A_PC    = 2'b00;
    localparam logic [SEL_W-1:0] A_OLDPC = 2'b01;
    localparam logic [SEL_W-1:0] A_REG   = 2'b10;
    // Operand B codes
    localparam logic [SEL_W-1:0] B_REG   = 2'b00;
    localparam logic [SEL_W-1:0] B_IMM   = 2'b01;
    localparam logic [SEL_W-1:0] B_FOUR  = 2'b10;

    typedef struct packed {
        logic             pc_update;
        logic             branch;
        logic             addr_sel;
        logic             mem_we;
        logic             ir_we;
        logic             rf_we;
        logic [SEL_W-1:0] res_sel;
        logic [SEL_W-1:0] a_sel;
        logic [SEL_W-1:0] b_sel;
        aluop_e           alu_op;
    } ctrl_word_t;

    typedef struct packed {
        state_e state;
    } seq_regs_t;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
#(
    parameter logic [OPC_W-1:0] JUMP8_OPC = 7'b1101110
) (
    input  state_e             cur,
    input  logic [OPC_W-1:0]   opcode,
    output state_e             nxt
);
    state_e from_decode;

    always_comb begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) from_decode = ST_ADDR;
        else if (opcode == OPC_ALU_R)                  from_decode = ST_EXE_R;
        else if (opcode == OPC_ALU_I)                  from_decode = ST_EXE_I;
        else if (opcode == OPC_JAL)                    from_decode = ST_JUMP;
        else if (opcode == OPC_BEQ)                    from_decode = ST_BRANCH;
        else if (opcode == JUMP8_OPC)                  from_decode = ST_JUMP8;
        else                                           from_decode = ST_FETCH;
    end

    always_comb begin
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = from_decode;
            ST_ADDR:   nxt = (opcode == OPC_LOAD)  ? ST_LDREAD :
                             (opcode == OPC_STORE) ? ST_STORE  : ST_FETCH;
            ST_LDREAD: nxt = ST_LDWB;
            ST_EXE_R,
            ST_EXE_I,
            ST_JUMP,
            ST_JUMP8:  nxt = ST_WB;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_state_decode.sv
module mcc_state_decode
    import mcc_pkg::*;
(
    input  state_e     cur,
    output ctrl_word_t cw
);
    always_comb begin
        cw = '0;
        case (cur)
            ST_FETCH: begin
                cw.ir_we     = 1'b1;
                cw.pc_update = 1'b1;
                cw.res_sel   = RES_ALULIVE;
                cw.a_sel     = A_PC;
                cw.b_sel     = B_FOUR;
            end
            ST_DECODE: begin
                cw.a_sel = A_OLDPC;
                cw.b_sel = B_IMM;
            end
            ST_ADDR: begin
                cw.a_sel = A_REG;
                cw.b_sel = B_IMM;
            end
            ST_LDREAD: cw.addr_sel = 1'b1;
            ST_LDWB: begin
                cw.rf_we   = 1'b1;
                cw.res_sel = RES_MEMDAT;
            end
            ST_STORE: begin
                cw.addr_sel = 1'b1;
                cw.mem_we   = 1'b1;
            end
            ST_EXE_R: begin
                cw.a_sel  = A_REG;
                cw.b_sel  = B_REG;
                cw.alu_op = AOP_FUNCT;
            end
            ST_WB: cw.rf_we = 1'b1;
            ST_EXE_I: begin
                cw.a_sel  = A_REG;
                cw.b_sel  = B_IMM;
                cw.alu_op = AOP_FUNCT;
            end
            ST_JUMP: begin
                cw.pc_update = 1'b1;
                cw.a_sel     = A_OLDPC;
                cw.b_sel     = B_FOUR;
            end
            ST_BRANCH: begin
                cw.branch = 1'b1;
                cw.a_sel  = A_REG;
                cw.b_sel  = B_REG;
                cw.alu_op = AOP_SUB;
            end
            ST_JUMP8: begin
                cw.pc_update = 1'b1;
                cw.a_sel     = A_PC;
                cw.b_sel     = B_FOUR;
            end
            default: cw = '0;
        endcase
    end
endmodule

// File: rtl/mcc_alu_decode.sv
module mcc_alu_decode
    import mcc_pkg::*;
(
    input  aluop_e            alu_op,
    input  logic [F3_W-1:0]   funct3,
    input  logic              funct7_b5,
    input  logic              opcode_b5,
    output logic [ALUC_W-1:0] alu_ctl
);
    always_comb begin
        case (alu_op)
            AOP_ADD: alu_ctl = 3'b000;
            AOP_SUB: alu_ctl = 3'b001;
            AOP_FUNCT: begin
                case (funct3)
                    3'b000:  alu_ctl = (opcode_b5 && funct7_b5) ? 3'b001 : 3'b000;
                    3'b010:  alu_ctl = 3'b101;
                    3'b110:  alu_ctl = 3'b011;
                    3'b111:  alu_ctl = 3'b010;
                    default: alu_ctl = 3'b000;
                endcase
            end
            default: alu_ctl = 3'b000;
        endcase
    end
endmodule

// File: rtl/mcc_imm_decode.sv
module mcc_imm_decode
    import mcc_pkg::*;
#(
    parameter logic [OPC_W-1:0] JUMP8_OPC = 7'b1101110
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [IMM_W-1:0] imm_sel
);
    always_comb begin
        if (opcode == OPC_STORE)                         imm_sel = 3'b001;
        else if (opcode == OPC_BEQ)                      imm_sel = 3'b010;
        else if (opcode == OPC_JAL || opcode == JUMP8_OPC) imm_sel = 3'b011;
        else                                             imm_sel = 3'b000;
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter logic [OPC_W-1:0] JUMP8_OPC = 7'b1101110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [F3_W-1:0]   funct3,
    input  logic              funct7_b5,
    input  logic              alu_zero,
    output logic              pc_we,
    output logic              addr_sel,
    output logic              mem_we,
    output logic              ir_we,
    output logic              rf_we,
    output logic [SEL_W-1:0]  res_sel,
    output logic [SEL_W-1:0]  alu_a_sel,
    output logic [SEL_W-1:0]  alu_b_sel,
    output logic [ALUC_W-1:0] alu_ctl,
    output logic [IMM_W-1:0]  imm_sel
);
    seq_regs_t  regs_d, regs_q;
    state_e     nxt_state;
    ctrl_word_t cw;

    mcc_next_state #(.JUMP8_OPC(JUMP8_OPC)) u_next (
        .cur    (regs_q.state),
        .opcode (opcode),
        .nxt    (nxt_state)
    );

    mcc_state_decode u_word (
        .cur (regs_q.state),
        .cw  (cw)
    );

    mcc_alu_decode u_alu (
        .alu_op    (cw.alu_op),
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .opcode_b5 (opcode[5]),
        .alu_ctl   (alu_ctl)
    );

    mcc_imm_decode #(.JUMP8_OPC(JUMP8_OPC)) u_imm (
        .opcode  (opcode),
        .imm_sel (imm_sel)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
        if (rst) regs_d.state = ST_FETCH;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pc_we     = cw.pc_update | (cw.branch & alu_zero);
    assign addr_sel  = cw.addr_sel;
    assign mem_we    = cw.mem_we;
    assign ir_we     = cw.ir_we;
    assign rf_we     = cw.rf_we;
    assign res_sel   = cw.res_sel;
    assign alu_a_sel = cw.a_sel;
    assign alu_b_sel = cw.b_sel;

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (regs_q.state == ST_FETCH));

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_FETCH) |=> (regs_q.state == ST_DECODE));

    // R3
    load_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_LDREAD) |=> (regs_q.state == ST_LDWB && rf_we));

    // R4
    write_enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, rf_we, ir_we}));

    // R7
    jump_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_JUMP) |=> (regs_q.state == ST_WB));

    // R8
    branch_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_BRANCH) |=> (regs_q.state == ST_FETCH && ir_we));

    // R9
    jump8_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_JUMP8) |=> (regs_q.state == ST_WB && rf_we));

    // R11
    decode_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_DECODE) |-> !(mem_we || rf_we || ir_we || pc_we));
endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode = '0;
    logic [2:0] funct3 = '0;
    logic       funct7_b5 = 1'b0;
    logic       alu_zero = 1'b0;
    logic       pc_we, addr_sel, mem_we, ir_we, rf_we;
    logic [1:0] res_sel, alu_a_sel, alu_b_sel;
    logic [2:0] alu_ctl, imm_sel;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mc_ctrl_fsm dut (
        .clk(clk), .rst(rst), .opcode(opcode), .funct3(funct3),
        .funct7_b5(funct7_b5), .alu_zero(alu_zero),
        .pc_we(pc_we), .addr_sel(addr_sel), .mem_we(mem_we), .ir_we(ir_we),
        .rf_we(rf_we), .res_sel(res_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_ctl(alu_ctl), .imm_sel(imm_sel)
    );

    function automatic int model_next(int s, logic [6:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 7'b0000011 || op == 7'b0100011) return 2;
                if (op == 7'b0110011) return 6;
                if (op == 7'b0010011) return 8;
                if (op == 7'b1101111) return 9;
                if (op == 7'b1100011) return 10;
                if (op == 7'b1101110) return 11;
                return 0;
            end
            2: return (op == 7'b0000011) ? 3 : ((op == 7'b0100011) ? 5 : 0);
            3: return 4;
            6, 8, 9, 11: return 7;
            default: return 0;
        endcase
    endfunction

    // funct3 decode of R5/R6; sub only for register form (opcode bit 5)
    function automatic logic [2:0] funct_alu(logic [6:0] op, logic [2:0] f3, logic f7);
        case (f3)
            3'b000:  return (op[5] && f7) ? 3'b001 : 3'b000;
            3'b010:  return 3'b101;
            3'b110:  return 3'b011;
            3'b111:  return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    // {pc_we, addr_sel, mem_we, ir_we, rf_we, res_sel, a_sel, b_sel, alu_ctl}
    function automatic logic [13:0] exp_ctl(int s, logic [6:0] op, logic [2:0] f3,
                                            logic f7, logic z);
        case (s)
            0:  return {5'b10010, 2'b10, 2'b00, 2'b10, 3'b000};
            1:  return {5'b00000, 2'b00, 2'b01, 2'b01, 3'b000};
            2:  return {5'b00000, 2'b00, 2'b10, 2'b01, 3'b000};
            3:  return {5'b01000, 2'b00, 2'b00, 2'b00, 3'b000};
            4:  return {5'b00001, 2'b01, 2'b00, 2'b00, 3'b000};
            5:  return {5'b01100, 2'b00, 2'b00, 2'b00, 3'b000};
            6:  return {5'b00000, 2'b00, 2'b10, 2'b00, funct_alu(op, f3, f7)};
            7:  return {5'b00001, 2'b00, 2'b00, 2'b00, 3'b000};
            8:  return {5'b00000, 2'b00, 2'b10, 2'b01, funct_alu(op, f3, f7)};
            9:  return {5'b10000, 2'b00, 2'b01, 2'b10, 3'b000};
            10: return {z, 4'b0000, 2'b00, 2'b10, 2'b00, 3'b001};
            11: return {5'b10000, 2'b00, 2'b00, 2'b10, 3'b000};
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] exp_imm(logic [6:0] op);
        if (op == 7'b0100011) return 3'b001;
        if (op == 7'b1100011) return 3'b010;
        if (op == 7'b1101111 || op == 7'b1101110) return 3'b011;
        return 3'b000;
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6, 7: return "R5";
            8: return "R6";
            9: return "R7";
            10: return "R8/R12";
            11: return "R9/R13";
            default: return "R11";
        endcase
    endfunction

    task automatic check_state(int s, logic [6:0] op);
        logic [13:0] got, exp;
        got = {pc_we, addr_sel, mem_we, ir_we, rf_we, res_sel, alu_a_sel, alu_b_sel, alu_ctl};
        exp = exp_ctl(s, op, funct3, funct7_b5, alu_zero);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s state %0d op=%b: control got %b expected %b",
                     tag_of(s), s, op, got, exp);
        end
        tests++;
        if (imm_sel !== exp_imm(op)) begin
            fails++;
            $display("FAIL R10 state %0d op=%b: imm_sel got %b expected %b",
                     s, op, imm_sel, exp_imm(op));
        end
    endtask

    task automatic run_instr(logic [6:0] op, logic [2:0] f3, logic f7, logic z0);
        int m;
        int n;
        int steps;
        logic [6:0] cur;
        @(negedge clk);
        rst = 1'b1; opcode = op; funct3 = f3; funct7_b5 = f7; alu_zero = z0; cur = op;
        @(negedge clk);
        rst = 1'b0; m = 0; steps = 0;
        for (int k = 0; k < 10; k++) begin
            check_state(m, cur);
            n = model_next(m, cur);
            // R9: opcode changed while in the custom jump state
            if (m == 11) begin cur = op ^ 7'h5A; opcode = cur; end
            alu_zero = ~alu_zero;
            @(negedge clk);
            m = n; steps++;
            if (m == 0) break;
        end
        check_state(m, cur);
        if (model_next(1, op) == 0) begin
            tests++;
            if (steps != 2 || m != 0) begin
                fails++;
                $display("FAIL R11 op=%b: cycles got %0d expected 2", op, steps);
            end
        end
    endtask

    initial begin
        #(20ns * 200000);
        tests++; fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1..R11: every opcode value through a full instruction
        for (int op = 0; op < 128; op++) run_instr(op[6:0], 3'b000, 1'b0, op[0]);
        // R5/R6: funct sweeps for both ALU forms
        for (int f = 0; f < 16; f++) begin
            run_instr(7'b0110011, f[2:0], f[3], 1'b0);
            run_instr(7'b0010011, f[2:0], f[3], 1'b1);
        end
        // R8/R12: branch with both zero phases
        run_instr(7'b1100011, 3'b000, 1'b0, 1'b0);
        run_instr(7'b1100011, 3'b000, 1'b0, 1'b1);
        // R9: custom jump again with funct bits set
        run_instr(7'b1101110, 3'b111, 1'b1, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule